// File: doc/BRIEF.md
# Masked-Level Interrupt Selector

This block collects interrupt events for a processor core and decides which priority level, if any, should interrupt the core next. Every interrupt number belongs to exactly one priority level. Its trigger kind is either level-sensitive or edge-sensitive. Both properties are fixed at elaboration time. A pending register records raised interrupts and an enable register gates them. Software can load the enable register, and it can set or clear pending bits with write-one masks.

Interrupt events arrive on a single strobed event port. An event names either an internal interrupt number directly, or an external pin index. A pin index is translated to an internal number through a mapping table that is a parameter. If an event names an internal number that does not exist, it is dropped and the error pulse is raised. The same happens when a pin index lies outside the table or maps to a missing number.

Every cycle, the block takes the registered pending and enable values and the registered core masking level. It searches the priority levels from the top down and stops above the masking level. The first level that owns an active interrupt becomes the selected level. That level and the request line are registered once before they leave the block.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: While reset is asserted, pending and enable registers read zero, and the request, selected level and error outputs are zero.
- R2: An accepted event with `lineActive`=1 sets the pending bit of its interrupt number one clock later. This holds for both trigger kinds.
- R3: An accepted event with `lineActive`=0 clears the pending bit of a level-sensitive interrupt. It leaves an edge-sensitive bit unchanged. Default edge-sensitive numbers are 1, 3, 5 and 6.
- R4: A software write with `swOp`=0 loads the enable register from `swData`. A write with `swOp`=3 changes nothing.
- R5: A software write with `swOp`=1 sets the pending bits that are one in `swData`. A write with `swOp`=2 clears them.
- R6: Default levels are 1 for {0,1,6}, 2 for {2,3,7} and 3 for {4,5}. Two clocks after a change, `irqLevel` equals the highest level L that is above the mask level and owns a bit of pending AND enable. If no such level exists, `irqLevel` is 0.
- R7: A level at or below `maskLevel` is never selected. With `maskLevel` at the top level (3), no request is raised.
- R8: A pending bit whose enable bit is zero never contributes to selection.
- R9: A direct event (`lineExt`=0) whose number is at or above the interrupt count leaves pending unchanged. It raises `errOut` for one cycle.
- R10: An external event (`lineExt`=1) is translated by the pin table. The default table is pin 0→2, 1→5, 2→7, 3→9. A pin index of 4 or more is rejected with `errOut`, and so is a mapped number at or above the interrupt count.
- R11: `irqReq` is 1 exactly when `irqLevel` is nonzero.
- R12: If an event sets a pending bit in the same cycle that a software clear names that bit, the bit ends cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lineStb | input | 1 | Interrupt event strobe |
| lineExt | input | 1 | 1: `lineIdx` is an external pin index; 0: an internal number |
| lineIdx | input | 5 | Pin index or interrupt number |
| lineActive | input | 1 | 1 raises the line, 0 lowers it |
| swWrEn | input | 1 | Software write strobe |
| swOp | input | 2 | 0 enable load, 1 pending set, 2 pending clear, 3 no operation |
| swData | input | NUM_IRQ | Write data or mask |
| maskLevel | input | LVL_W | Current core masking level |
| pendingOut | output | NUM_IRQ | Pending register |
| enableOut | output | NUM_IRQ | Enable register |
| irqReq | output | 1 | Interrupt request to the core |
| irqLevel | output | LVL_W | Selected level, 0 when none |
| errOut | output | 1 | One-cycle pulse for a rejected event |

## Verification
Selection is tried with these patterns:
- Two levels active at once, which shows whether the scan runs top-down.
- A mask level that steps down from 3 to 0 over a fixed pending set, which shows whether the boundary is strict or inclusive.
- Pending bits with their enables cleared, which separates the pending register from the active set.

Lowering events go once to a level-sensitive number and once to an edge-sensitive number. This tells apart the two clearing rules. Pin events cover every outcome of the table: a valid mapping, a pin past the table's end, and a pin whose mapping names a missing interrupt.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

  typedef enum logic [1:0] {
    SW_EN_LOAD  = 2'd0,
    SW_PEND_SET = 2'd1,
    SW_PEND_CLR = 2'd2,
    SW_NOP      = 2'd3
  } swOp_e;

  // strobes from the decode stage to the register/select stage
  typedef struct packed {
    logic       lineGo;      // accepted event
    logic       lineActive;  // event polarity
    logic [4:0] lineNum;     // internal interrupt number
    logic       enLoad;      // software loads enable
    logic       pendSet;     // software sets pending bits
    logic       pendClr;     // software clears pending bits
    logic       reject;      // event refused
  } strobe_t;

endpackage

// File: rtl/lvl_irq_decode.sv
module lvl_irq_decode
  import lvl_irq_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int NUM_EXT = 4,
  parameter logic [5*NUM_EXT-1:0] EXT_MAP = '0
) (
  input  logic       lineStb,
  input  logic       lineExt,
  input  logic [4:0] lineIdx,
  input  logic       lineActive,
  input  logic       swWrEn,
  input  logic [1:0] swOp,
  output strobe_t    stb
);

  localparam logic [5:0] EXT_LIMIT = 6'(NUM_EXT);
  localparam logic [5:0] IRQ_LIMIT = 6'(NUM_IRQ);

  logic [4:0] mappedNum;
  logic       pinOk;
  logic       numOk;
  swOp_e      op;

  // translate an external pin index through the table
  always_comb begin
    mappedNum = lineIdx;
    if (lineExt) begin
      mappedNum = '0;
      for (int e = 0; e < NUM_EXT; e++) begin
        if (lineIdx == 5'(e)) mappedNum = EXT_MAP[5*e +: 5];
      end
    end
  end

  assign pinOk = !lineExt || ({1'b0, lineIdx} < EXT_LIMIT);
  assign numOk = {1'b0, mappedNum} < IRQ_LIMIT;
  assign op    = swOp_e'(swOp);

  always_comb begin
    stb            = '0;
    stb.lineGo     = lineStb && pinOk && numOk;
    stb.lineActive = lineActive;
    stb.lineNum    = mappedNum;
    stb.reject     = lineStb && !(pinOk && numOk);
    stb.enLoad     = swWrEn && (op == SW_EN_LOAD);
    stb.pendSet    = swWrEn && (op == SW_PEND_SET);
    stb.pendClr    = swWrEn && (op == SW_PEND_CLR);
  end

endmodule

// File: rtl/lvl_irq_core.sv
module lvl_irq_core
  import lvl_irq_pkg::*;
#(
  parameter int NUM_IRQ    = 8,
  parameter int NUM_LEVELS = 3,
  parameter int LVL_W      = 2,
  parameter logic [4*NUM_IRQ-1:0] IRQ_LEVEL_MAP = '0,
  parameter logic [NUM_IRQ-1:0]   IRQ_EDGE      = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [NUM_IRQ-1:0] swData,
  input  logic [LVL_W-1:0]   maskLevel,
  output logic [NUM_IRQ-1:0] pendingOut,
  output logic [NUM_IRQ-1:0] enableOut,
  output logic               irqReq,
  output logic [LVL_W-1:0]   irqLevel,
  output logic               errOut
);

  logic [NUM_IRQ-1:0] pendReg, enReg, pendNext;
  logic [NUM_IRQ-1:0] lineSetV, lineClrV, swSetV, swClrV, activeSet;
  logic [LVL_W-1:0]   maskReg, selLvl;
  logic               hit;
  logic [NUM_IRQ-1:0] lvlMask [1:NUM_LEVELS];

  // per-interrupt event decode; lowering only clears level-sensitive bits
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    logic match;
    assign match       = stb.lineGo && (stb.lineNum == 5'(i));
    assign lineSetV[i] = match && stb.lineActive;
    assign lineClrV[i] = match && !stb.lineActive && !IRQ_EDGE[i];
  end

  // membership mask of each priority level
  for (genvar l = 1; l <= NUM_LEVELS; l++) begin : g_lvl
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
      assign lvlMask[l][i] = (IRQ_LEVEL_MAP[4*i +: 4] == 4'(l));
    end
  end

  assign swSetV   = stb.pendSet ? swData : '0;
  assign swClrV   = stb.pendClr ? swData : '0;
  assign pendNext = (pendReg | lineSetV | swSetV) & ~(lineClrV | swClrV);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendReg <= '0;
      enReg   <= '0;
      maskReg <= '0;
      errOut  <= 1'b0;
    end else begin
      pendReg <= pendNext;
      if (stb.enLoad) enReg <= swData;
      maskReg <= maskLevel;
      errOut  <= stb.reject;
    end
  end

  // top-down scan, stopping strictly above the masking level
  assign activeSet = pendReg & enReg;
  always_comb begin
    hit    = 1'b0;
    selLvl = '0;
    for (int l = NUM_LEVELS; l >= 1; l--) begin
      if (!hit && (LVL_W'(l) > maskReg) && (|(lvlMask[l] & activeSet))) begin
        hit    = 1'b1;
        selLvl = LVL_W'(l);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqReq   <= 1'b0;
      irqLevel <= '0;
    end else begin
      irqReq   <= hit;
      irqLevel <= selLvl;
    end
  end

  assign pendingOut = pendReg;
  assign enableOut  = enReg;

endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lvl_irq_pkg::*;
#(
  parameter int NUM_IRQ    = 8,
  parameter int NUM_LEVELS = 3,
  parameter int NUM_EXT    = 4,
  parameter logic [4*NUM_IRQ-1:0] IRQ_LEVEL_MAP = 32'h2133_2211,
  parameter logic [NUM_IRQ-1:0]   IRQ_EDGE      = 8'h6A,
  parameter logic [5*NUM_EXT-1:0] EXT_MAP       = {5'd9, 5'd7, 5'd5, 5'd2},
  localparam int LVL_W = $clog2(NUM_LEVELS + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lineStb,
  input  logic               lineExt,
  input  logic [4:0]         lineIdx,
  input  logic               lineActive,
  input  logic               swWrEn,
  input  logic [1:0]         swOp,
  input  logic [NUM_IRQ-1:0] swData,
  input  logic [LVL_W-1:0]   maskLevel,
  output logic [NUM_IRQ-1:0] pendingOut,
  output logic [NUM_IRQ-1:0] enableOut,
  output logic               irqReq,
  output logic [LVL_W-1:0]   irqLevel,
  output logic               errOut
);

  strobe_t stb;

  lvl_irq_decode #(
    .NUM_IRQ (NUM_IRQ),
    .NUM_EXT (NUM_EXT),
    .EXT_MAP (EXT_MAP)
  ) u_decode (
    .lineStb    (lineStb),
    .lineExt    (lineExt),
    .lineIdx    (lineIdx),
    .lineActive (lineActive),
    .swWrEn     (swWrEn),
    .swOp       (swOp),
    .stb        (stb)
  );

  lvl_irq_core #(
    .NUM_IRQ       (NUM_IRQ),
    .NUM_LEVELS    (NUM_LEVELS),
    .LVL_W         (LVL_W),
    .IRQ_LEVEL_MAP (IRQ_LEVEL_MAP),
    .IRQ_EDGE      (IRQ_EDGE)
  ) u_core (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .swData     (swData),
    .maskLevel  (maskLevel),
    .pendingOut (pendingOut),
    .enableOut  (enableOut),
    .irqReq     (irqReq),
    .irqLevel   (irqLevel),
    .errOut     (errOut)
  );

endmodule

// File: rtl/lvl_irq_checker.sv
module lvl_irq_checker #(
  parameter int NUM_IRQ = 8,
  parameter int LVL_W   = 2,
  parameter logic [NUM_IRQ-1:0] IRQ_EDGE = '0
) (
  input logic               clk,
  input logic               rstN,
  input logic               lineStb,
  input logic               swWrEn,
  input logic [1:0]         swOp,
  input logic [LVL_W-1:0]   maskLevel,
  input logic [NUM_IRQ-1:0] pendingOut,
  input logic [NUM_IRQ-1:0] enableOut,
  input logic               irqReq,
  input logic [LVL_W-1:0]   irqLevel,
  input logic               errOut
);

  assert_req_tracks_level_R11: assert property (@(posedge clk) disable iff (!rstN)
    irqReq == (irqLevel != '0));

  assert_level_above_mask_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (irqLevel > $past(maskLevel, 2)));

  assert_edge_bit_kept_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(swWrEn && (swOp == 2'd2)) |->
      (($past(pendingOut) & IRQ_EDGE & ~pendingOut) == '0));

  assert_idle_when_inactive_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pendingOut & enableOut) == '0) |-> !irqReq);

  assert_err_needs_event_R9: assert property (@(posedge clk) disable iff (!rstN)
    errOut |-> $past(lineStb));

endmodule

bind lvl_irq_ctrl lvl_irq_checker #(
  .NUM_IRQ  (NUM_IRQ),
  .LVL_W    (LVL_W),
  .IRQ_EDGE (IRQ_EDGE)
) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .lineStb    (lineStb),
  .swWrEn     (swWrEn),
  .swOp       (swOp),
  .maskLevel  (maskLevel),
  .pendingOut (pendingOut),
  .enableOut  (enableOut),
  .irqReq     (irqReq),
  .irqLevel   (irqLevel),
  .errOut     (errOut)
);

// File: tb/test_lvl_irq_ctrl.sv
module test_lvl_irq_ctrl;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lineStb = 1'b0, lineExt = 1'b0, lineActive = 1'b0;
  logic [4:0] lineIdx = '0;
  logic       swWrEn = 1'b0;
  logic [1:0] swOp = '0;
  logic [7:0] swData = '0;
  logic [1:0] maskLevel = '0;
  logic [7:0] pendingOut, enableOut;
  logic       irqReq, errOut;
  logic [1:0] irqLevel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  lvl_irq_ctrl i_lvl_irq_ctrl (
    .clk(clk), .rstN(rstN), .lineStb(lineStb), .lineExt(lineExt),
    .lineIdx(lineIdx), .lineActive(lineActive), .swWrEn(swWrEn),
    .swOp(swOp), .swData(swData), .maskLevel(maskLevel),
    .pendingOut(pendingOut), .enableOut(enableOut), .irqReq(irqReq),
    .irqLevel(irqLevel), .errOut(errOut)
  );

  typedef struct packed {
    logic [3:0] req;
    logic       stb, ext;
    logic [4:0] idx;
    logic       act, wr;
    logic [1:0] op;
    logic [7:0] data;
    logic [1:0] mask;
    logic [7:0] expPend;
    logic [1:0] expLvl;
    logic       expErr;
  } vec_t;

  localparam int NV = 22;
  //  req  stb  ext  idx   act  wr   op    data   mask  pend   lvl   err
  localparam logic [35:0] VEC [NV] = '{
    {4'd4, 1'b0,1'b0,5'd0,1'b0,1'b1,2'd0,8'hFF,2'd0,8'h00,2'd0,1'b0}, // R4 enable all
    {4'd2, 1'b1,1'b0,5'd0,1'b1,1'b0,2'd0,8'h00,2'd0,8'h01,2'd1,1'b0}, // R2 raise 0
    {4'd6, 1'b1,1'b0,5'd4,1'b1,1'b0,2'd0,8'h00,2'd0,8'h11,2'd3,1'b0}, // R6 top level wins
    {4'd7, 1'b0,1'b0,5'd0,1'b0,1'b0,2'd0,8'h00,2'd3,8'h11,2'd0,1'b0}, // R7 mask all
    {4'd7, 1'b0,1'b0,5'd0,1'b0,1'b0,2'd0,8'h00,2'd2,8'h11,2'd3,1'b0}, // R7 3 above 2
    {4'd3, 1'b1,1'b0,5'd4,1'b0,1'b0,2'd0,8'h00,2'd1,8'h01,2'd0,1'b0}, // R3 level bit drops
    {4'd6, 1'b0,1'b0,5'd0,1'b0,1'b0,2'd0,8'h00,2'd0,8'h01,2'd1,1'b0}, // R6 level 1
    {4'd2, 1'b1,1'b0,5'd3,1'b1,1'b0,2'd0,8'h00,2'd0,8'h09,2'd2,1'b0}, // R2 edge raise
    {4'd3, 1'b1,1'b0,5'd3,1'b0,1'b0,2'd0,8'h00,2'd0,8'h09,2'd2,1'b0}, // R3 edge kept
    {4'd9, 1'b1,1'b0,5'd9,1'b1,1'b0,2'd0,8'h00,2'd0,8'h09,2'd2,1'b1}, // R9 bad number
    {4'd8, 1'b0,1'b0,5'd0,1'b0,1'b1,2'd0,8'h01,2'd0,8'h09,2'd1,1'b0}, // R8 disable 3
    {4'd5, 1'b0,1'b0,5'd0,1'b0,1'b1,2'd2,8'h09,2'd0,8'h00,2'd0,1'b0}, // R5 clear
    {4'd8, 1'b0,1'b0,5'd0,1'b0,1'b1,2'd1,8'h30,2'd0,8'h30,2'd0,1'b0}, // R8 set, disabled
    {4'd4, 1'b0,1'b0,5'd0,1'b0,1'b1,2'd0,8'hFF,2'd0,8'h30,2'd3,1'b0}, // R4 enable all
    {4'd5, 1'b0,1'b0,5'd0,1'b0,1'b1,2'd2,8'h30,2'd0,8'h00,2'd0,1'b0}, // R5 clear
    {4'd10,1'b1,1'b1,5'd2,1'b1,1'b0,2'd0,8'h00,2'd0,8'h80,2'd2,1'b0}, // R10 pin2->7
    {4'd10,1'b1,1'b1,5'd3,1'b1,1'b0,2'd0,8'h00,2'd0,8'h80,2'd2,1'b1}, // R10 pin3->9 bad
    {4'd10,1'b1,1'b1,5'd5,1'b1,1'b0,2'd0,8'h00,2'd0,8'h80,2'd2,1'b1}, // R10 pin5 bad
    {4'd10,1'b1,1'b1,5'd0,1'b1,1'b0,2'd0,8'h00,2'd0,8'h84,2'd2,1'b0}, // R10 pin0->2
    {4'd4, 1'b0,1'b0,5'd0,1'b0,1'b1,2'd3,8'hFF,2'd0,8'h84,2'd2,1'b0}, // R4 nop
    {4'd5, 1'b0,1'b0,5'd0,1'b0,1'b1,2'd1,8'h40,2'd0,8'hC4,2'd2,1'b0}, // R5 set 6
    {4'd3, 1'b1,1'b1,5'd2,1'b0,1'b0,2'd0,8'h00,2'd0,8'h44,2'd2,1'b0}  // R3 pin2 lowers 7
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input logic [1:0] m);
    lineStb = 1'b0; swWrEn = 1'b0; maskLevel = m;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset pending", 32'(pendingOut), 0);
    chk("R1 reset enable", 32'(enableOut), 0);
    chk("R1 reset req/level/err", {29'd0, irqReq, irqLevel} | 32'(errOut), 0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = vec_t'(VEC[i]);
      lineStb = v.stb; lineExt = v.ext; lineIdx = v.idx; lineActive = v.act;
      swWrEn = v.wr; swOp = v.op; swData = v.data; maskLevel = v.mask;
      @(posedge clk); @(negedge clk);
      chk($sformatf("R%0d vec%0d pending", v.req, i), 32'(pendingOut), 32'(v.expPend));
      chk($sformatf("R%0d vec%0d error", v.req, i), 32'(errOut), 32'(v.expErr));
      idle(v.mask);
      @(posedge clk); @(negedge clk);
      chk($sformatf("R%0d vec%0d level", v.req, i), 32'(irqLevel), 32'(v.expLvl));
      chk($sformatf("R11 vec%0d request", i), 32'(irqReq), 32'(v.expLvl != 0));
    end

    // R4: the no-op write left the enable register untouched
    chk("R4 enable after nop", 32'(enableOut), 32'hFF);

    // R1: reset asserted mid-run clears state
    rstN = 1'b0;
    #1;
    chk("R1 mid reset pending", 32'(pendingOut), 0);
    chk("R1 mid reset enable", 32'(enableOut), 0);
    chk("R1 mid reset request", 32'(irqReq), 0);
    @(negedge clk);
    rstN = 1'b1;

    // R12: raise and software clear of the same bit in one cycle
    lineStb = 1'b1; lineExt = 1'b0; lineIdx = 5'd0; lineActive = 1'b1;
    swWrEn = 1'b1; swOp = 2'd2; swData = 8'h01; maskLevel = 2'd0;
    @(posedge clk); @(negedge clk);
    chk("R12 clear wins", 32'(pendingOut), 0);
    idle(2'd0);
    lineStb = 1'b1; lineIdx = 5'd1;
    @(posedge clk); @(negedge clk);
    chk("R2 raise after reset", 32'(pendingOut), 32'h02);
    idle(2'd0);
    @(posedge clk); @(negedge clk);
    chk("R8 no request with enable cleared", 32'(irqReq), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule